// File: doc/BRIEF.md
# Ethernet receive frame status generator

This block follows one received Ethernet frame, byte by byte, as it is written into a chain of receive buffers of configurable size. Each time a buffer is closed, it emits a 16-bit status word with a one-cycle valid strobe. A buffer is closed either because it is full or because the frame has ended. The word marks whether the buffer opened the frame and whether it closed it. Only on the closing buffer does the word also carry the destination-address class and the error summary.

The upstream receiver supplies the byte stream with start and end strobes. At the end-of-frame beat it also supplies the count of dangling bits, the CRC and code-group error results, the FIFO-overrun and truncation indications, and the address filter's verdict. Configuration sets promiscuous acceptance, the upper and lower frame-length limits, whether short frames are flagged, and the buffer size in bytes. CRC computation, address hashing and data movement happen elsewhere.

Bits are numbered from the MSB, so position p sits at vector index 15-p. Positions 0 to 3 and 6 are always zero.

Top module: `rx_frame_status`

## Requirements
- R1: A status word is emitted (`st_valid` high for one cycle, the cycle after the beat) when a beat fills the buffer to `cfg_buf_bytes` bytes or carries end-of-frame; on every other cycle `st_valid` is low.
- R2: The first-buffer flag (position 5, index 10) is 1 only in the word of the buffer that holds the start-of-frame byte, and 0 in all later buffers of that frame.
- R3: The last-buffer flag (position 4, index 11) is 1 only in the word closed by end-of-frame; in every other word indices 8 down to 0 are all zero.
- R4: The broadcast flag (position 8, index 7) is set when the first six frame bytes are all 0xFF.
- R5: The multicast flag (position 9, index 6) is set when bit 0 of the first frame byte is 1 and the frame is not broadcast; broadcast and multicast are never both set.
- R6: The miss flag (position 7, index 8) is set only when `cfg_promisc` is 1 and `in_addr_hit` is 0.
- R7: The length flag (position 10, index 5) is set when the frame byte count exceeds `cfg_max_len`.
- R8: The non-octet flag (position 11, index 4) is set when `in_tail_bits` is nonzero at end-of-frame.
- R9: The short flag (position 12, index 3) is set when `cfg_short_chk` is 1 and the frame byte count is below `cfg_min_len`.
- R10: The CRC flag (position 13, index 2) is set when `in_crc_bad` is 1 on a frame with zero tail bits, or whenever `in_code_bad` is 1.
- R11: The overrun flag (position 14, index 1) follows `in_overrun` and, when set, forces miss, length, non-octet, short and CRC to zero. The truncation flag (position 15, index 0) follows `in_trunc`.
- R12: After reset `st_valid` and `st_word` are zero; positions 0 to 3 and 6 (indices 15:12 and 9) are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat present |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last whole byte of a frame |
| in_data | input | 8 | Frame byte |
| in_tail_bits | input | 3 | Bits received after the last whole byte (sampled at end-of-frame) |
| in_crc_bad | input | 1 | CRC check failed (sampled at end-of-frame) |
| in_code_bad | input | 1 | Code-group error seen (sampled at end-of-frame) |
| in_overrun | input | 1 | FIFO overrun during the frame (sampled at end-of-frame) |
| in_trunc | input | 1 | Frame was truncated (sampled at end-of-frame) |
| in_addr_hit | input | 1 | Address filter matched (sampled at end-of-frame) |
| cfg_promisc | input | 1 | Promiscuous acceptance enabled |
| cfg_max_len | input | 16 | Longest legal frame in bytes |
| cfg_min_len | input | 16 | Shortest legal frame in bytes |
| cfg_short_chk | input | 1 | Flag short frames |
| cfg_buf_bytes | input | 16 | Receive buffer size in bytes (at least 1) |
| st_valid | output | 1 | Status word strobe |
| st_word | output | 16 | Buffer status word |

## Verification
The sweep crosses frame lengths 1 to 20 with buffer sizes 3, 4 and 8. That covers frames ending exactly on a buffer boundary, where a design that closed a full buffer before testing end-of-frame would emit an extra empty word or lose the last flag. Frames shorter than six bytes with an all-ones prefix must come out multicast rather than broadcast. An address that is all ones except for the sixth byte catches a classifier that looks at too few octets. Overrun is combined with every other error source, so a design that left a single error bit unmasked would show it. CRC errors arrive both with and without tail bits, so a design that ignored alignment, or that dropped code-group errors, would mark the wrong frames.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int STW = 16;
  // vector indices (position p from the MSB maps to 15-p)
  localparam int IX_LAST  = 11;
  localparam int IX_FIRST = 10;
  localparam int IX_MISS  = 8;
  localparam int IX_BC    = 7;
  localparam int IX_MC    = 6;
  localparam int IX_LG    = 5;
  localparam int IX_NO    = 4;
  localparam int IX_SH    = 3;
  localparam int IX_CR    = 2;
  localparam int IX_OV    = 1;
  localparam int IX_TR    = 0;

  typedef struct packed {
    logic miss;
    logic bc;
    logic mc;
    logic lg;
    logic no;
    logic sh;
    logic cr;
    logic ov;
    logic tr;
  } rx_flags_t;
endpackage

// File: rtl/rx_da_classify.sv
module rx_da_classify #(
  parameter int LEN_W      = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  input  logic [7:0]       data,
  input  logic [LEN_W-1:0] idx,
  output logic             is_bc,
  output logic             is_mc
);
  localparam logic [LEN_W-1:0] LAST_IX = LEN_W'(ADDR_BYTES - 1);

  logic ones_q, grp_q, ones_now, grp_now, in_addr;

  always_comb begin
    in_addr  = idx <= LAST_IX;
    if (sof) begin
      ones_now = (data == 8'hFF);
      grp_now  = data[0];
    end else begin
      ones_now = in_addr ? (ones_q && data == 8'hFF) : ones_q;
      grp_now  = grp_q;
    end
    is_bc = ones_now && (idx >= LAST_IX);
    is_mc = grp_now && !is_bc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= 1'b0;
      grp_q  <= 1'b0;
    end else if (beat) begin
      ones_q <= ones_now;
      grp_q  <= grp_now;
    end
  end
endmodule

// File: rtl/rx_buf_track.sv
module rx_buf_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  input  logic [LEN_W-1:0] buf_bytes,
  output logic             close,
  output logic             first
);
  logic [LEN_W-1:0] fill_q, fill_next;
  logic             first_q;

  always_comb begin
    fill_next = sof ? LEN_W'(1) : fill_q + LEN_W'(1);
    first     = sof | first_q;
    close     = beat && (eof || fill_next == buf_bytes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      first_q <= 1'b0;
    end else if (beat) begin
      if (close) begin
        fill_q  <= '0;
        first_q <= 1'b0;
      end else begin
        fill_q  <= fill_next;
        first_q <= first;
      end
    end
  end
endmodule

// File: rtl/rx_err_eval.sv
module rx_err_eval
  import rx_status_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] frame_len,
  input  logic [2:0]       tail_bits,
  input  logic             crc_bad,
  input  logic             code_bad,
  input  logic             overrun,
  input  logic             trunc,
  input  logic             addr_hit,
  input  logic             promisc,
  input  logic [LEN_W-1:0] max_len,
  input  logic [LEN_W-1:0] min_len,
  input  logic             short_chk,
  input  logic             is_bc,
  input  logic             is_mc,
  output rx_flags_t        flags
);
  logic aligned;

  always_comb begin
    aligned    = (tail_bits == 3'd0);
    flags.ov   = overrun;
    flags.tr   = trunc;
    flags.bc   = is_bc;
    flags.mc   = is_mc;
    flags.miss = promisc && !addr_hit && !overrun;
    flags.lg   = (frame_len > max_len) && !overrun;
    flags.no   = !aligned && !overrun;
    flags.sh   = short_chk && (frame_len < min_len) && !overrun;
    flags.cr   = ((crc_bad && aligned) || code_bad) && !overrun;
  end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rx_status_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [2:0]       in_tail_bits,
  input  logic             in_crc_bad,
  input  logic             in_code_bad,
  input  logic             in_overrun,
  input  logic             in_trunc,
  input  logic             in_addr_hit,
  input  logic             cfg_promisc,
  input  logic [LEN_W-1:0] cfg_max_len,
  input  logic [LEN_W-1:0] cfg_min_len,
  input  logic             cfg_short_chk,
  input  logic [LEN_W-1:0] cfg_buf_bytes,
  output logic             st_valid,
  output logic [STW-1:0]   st_word
);
  logic [LEN_W-1:0] cnt_q, idx, len_now;
  logic             is_bc, is_mc, close, first;
  rx_flags_t        flags;
  logic [STW-1:0]   word;

  always_comb begin
    idx     = in_sof ? '0 : cnt_q;
    len_now = (idx == '1) ? idx : idx + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (in_valid) cnt_q <= len_now;
  end

  rx_da_classify #(.LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES)) i_da (
    .clk(clk), .rst(rst), .beat(in_valid), .sof(in_sof), .data(in_data),
    .idx(idx), .is_bc(is_bc), .is_mc(is_mc)
  );

  rx_buf_track #(.LEN_W(LEN_W)) i_buf (
    .clk(clk), .rst(rst), .beat(in_valid), .sof(in_sof), .eof(in_eof),
    .buf_bytes(cfg_buf_bytes), .close(close), .first(first)
  );

  rx_err_eval #(.LEN_W(LEN_W)) i_err (
    .frame_len(len_now), .tail_bits(in_tail_bits), .crc_bad(in_crc_bad),
    .code_bad(in_code_bad), .overrun(in_overrun), .trunc(in_trunc),
    .addr_hit(in_addr_hit), .promisc(cfg_promisc), .max_len(cfg_max_len),
    .min_len(cfg_min_len), .short_chk(cfg_short_chk), .is_bc(is_bc),
    .is_mc(is_mc), .flags(flags)
  );

  always_comb begin
    word           = '0;
    word[IX_FIRST] = first;
    if (in_eof) begin
      word[IX_LAST] = 1'b1;
      word[IX_MISS] = flags.miss;
      word[IX_BC]   = flags.bc;
      word[IX_MC]   = flags.mc;
      word[IX_LG]   = flags.lg;
      word[IX_NO]   = flags.no;
      word[IX_SH]   = flags.sh;
      word[IX_CR]   = flags.cr;
      word[IX_OV]   = flags.ov;
      word[IX_TR]   = flags.tr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_word  <= '0;
    end else begin
      st_valid <= close;
      if (close) st_word <= word;
    end
  end
endmodule

// File: rtl/rx_frame_status_chk.sv
module rx_frame_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        st_valid,
  input logic [15:0] st_word,
  input logic        cfg_promisc
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else if (st_valid) open_q <= !st_word[11];
  end

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_word[15:12] == 4'd0 && !st_word[9]));

  p_middle_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_word[11]) |-> (st_word[8:0] == 9'd0));

  p_overrun_mask_r11: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_word[1]) |-> (!st_word[8] && st_word[5:2] == 4'd0));

  p_bc_mc_excl_r5: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> !(st_word[7] && st_word[6]));

  p_first_once_r2: assert property (@(posedge clk) disable iff (rst)
    (st_valid && open_q) |-> !st_word[10]);

  p_miss_promisc_r6: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_word[8]) |-> $past(cfg_promisc));
endmodule

bind rx_frame_status rx_frame_status_chk i_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_word(st_word),
  .cfg_promisc(cfg_promisc)
);

// File: tb/test_rx_frame_status.sv
module test_rx_frame_status;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 16;
  localparam int MIN_LEN = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic [2:0] in_tail_bits = 0;
  logic in_crc_bad = 0, in_code_bad = 0, in_overrun = 0, in_trunc = 0, in_addr_hit = 0;
  logic cfg_promisc = 0, cfg_short_chk = 0;
  logic [15:0] cfg_max_len = 16'(MAX_LEN), cfg_min_len = 16'(MIN_LEN), cfg_buf_bytes = 16'd4;
  logic st_valid;
  logic [15:0] st_word;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_status i_rx_frame_status (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_tail_bits(in_tail_bits), .in_crc_bad(in_crc_bad),
    .in_code_bad(in_code_bad), .in_overrun(in_overrun), .in_trunc(in_trunc),
    .in_addr_hit(in_addr_hit), .cfg_promisc(cfg_promisc), .cfg_max_len(cfg_max_len),
    .cfg_min_len(cfg_min_len), .cfg_short_chk(cfg_short_chk),
    .cfg_buf_bytes(cfg_buf_bytes), .st_valid(st_valid), .st_word(st_word)
  );

  function automatic string req_of(int ix);
    case (ix)
      11: return "R3";  10: return "R2";  8: return "R6";  7: return "R4";
      6: return "R5";   5: return "R7";   4: return "R8";  3: return "R9";
      2: return "R10";  1: return "R11";  0: return "R11";
      default: return "R12";
    endcase
  endfunction

  // byte at position i for address style t: 0 broadcast, 1 multicast, 2 unicast, 3 near-broadcast
  function automatic logic [7:0] byte_of(int t, int i);
    if (i >= 6) return 8'(i);
    case (t)
      0: return 8'hFF;
      1: return (i == 0) ? 8'h01 : 8'h22;
      2: return (i == 0) ? 8'h02 : 8'h22;
      default: return (i == 5) ? 8'hFE : 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic beat(input logic s, input logic e, input logic [7:0] d,
                      input bit ev, input logic [15:0] ew);
    in_valid = 1; in_sof = s; in_eof = e; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    // R1: strobe only on a closing beat
    check(st_valid === ev, "R1", {15'd0, st_valid}, {15'd0, ev});
    if (ev && st_word !== ew) begin
      int ix = 0;
      for (int b = 15; b >= 0; b--) if (st_word[b] !== ew[b]) ix = b;
      check(1'b0, req_of(ix), st_word, ew);
    end else if (ev) check(1'b1, "R3", st_word, ew);
  endtask

  task automatic frame(input int bs, input int t, input int len, input int n);
    bit crc, code, ov, tr, hit, pr, sc;
    int tail;
    logic [15:0] w;
    bit bc, grp;
    crc = n[0]; code = (n % 5 == 0); ov = (n % 7 == 3); tr = (n % 6 == 1);
    hit = n[1]; pr = n[2]; sc = n[3];
    tail = (n % 4 == 3) ? (n % 7) + 1 : 0;
    cfg_buf_bytes = 16'(bs); cfg_promisc = pr; cfg_short_chk = sc;
    in_crc_bad = crc; in_code_bad = code; in_overrun = ov; in_trunc = tr;
    in_addr_hit = hit; in_tail_bits = 3'(tail);
    bc  = (t == 0) && (len >= 6);                 // R4
    grp = (t != 2);
    for (int i = 0; i < len; i++) begin
      bit last = (i == len - 1);
      bit cl = last || ((i % bs) == bs - 1);
      w = '0;
      w[10] = (i < bs);                           // R2
      if (last) begin
        w[11] = 1;                                // R3
        w[7] = bc;
        w[6] = grp && !bc;                        // R5
        w[1] = ov;                                // R11
        w[0] = tr;
        if (!ov) begin
          w[8] = pr && !hit;                      // R6
          w[5] = len > MAX_LEN;                   // R7
          w[4] = tail != 0;                       // R8
          w[3] = sc && (len < MIN_LEN);           // R9
          w[2] = (crc && tail == 0) || code;      // R10
        end
      end
      beat(i == 0, last, byte_of(t, i), cl, w);
    end
    // idle cycle: no strobe (R1)
    @(posedge clk); @(negedge clk);
    check(st_valid === 1'b0, "R1", {15'd0, st_valid}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n = 0;
    int sizes[3] = '{3, 4, 8};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check(st_valid === 1'b0 && st_word === 16'd0, "R12", st_word, 16'd0);
    rst = 0;
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 4; t++)
        for (int len = 1; len <= 20; len++) begin
          frame(sizes[s], t, len, n);
          n++;
        end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule